// File: doc/BRIEF.md
# Serial Register Write Port with Mode Detect

This block is the serial write side of a control port for a bank of configuration registers. It watches three shared pins: a chip-select line that doubles as a bus-address strap, a serial clock and a serial data line. It samples them with the fast system clock. After reset the port assumes the two-wire bus is in charge and treats the shared pin as a plain address strap. The first falling edge seen on that pin moves the port into four-wire serial mode. It stays in that mode until the next reset.

In serial mode a frame opens when chip select drops. The frame carries a fixed identity byte, then a pointer byte, then any number of data bytes. The pointer byte holds a target register address and an auto-advance flag. Each accepted data byte comes out as a single-cycle write strobe with address and data on a parallel register port. With the flag set, the address steps by one after each byte. With the flag clear, every byte lands on the same register. A frame whose identity byte does not match is ignored to its end. A byte cut short by chip select rising is dropped. The port never drives data back.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset `spi_mode` is 0. It becomes 1 a few cycles after the first high-to-low change of `ad0_cs` that follows reset, and it then stays 1 until the next reset.
- R2: If `ad0_cs` is already low when reset ends and stays low, this is not a falling edge, and `spi_mode` stays 0.
- R3: While `spi_mode` is 0, no activity on `cclk` and `cdin` causes a register write.
- R4: In serial mode, `cdin` is sampled on each rising edge of `cclk` while `ad0_cs` is low. Bits arrive most significant first, and a byte is complete on its eighth rising edge.
- R5: The first byte of a frame must be 0x30. If it is any other value, no write occurs until `ad0_cs` goes high, and the following frame is decoded normally.
- R6: The second byte is the pointer. Bit 7 is the auto-advance flag, and bits [ADDR_W-1:0] are the register address; any bits between are ignored. The third byte is written to that address.
- R7: With the flag at 1, each further data byte goes to the previous address plus one, wrapping modulo 2^ADDR_W.
- R8: With the flag at 0, every data byte in the frame is written to the pointer address.
- R9: `ad0_cs` rising part-way through a byte discards that partial byte and restarts the frame decode. A frame that holds only the identity and pointer bytes writes nothing.
- R10: Every register write is a strobe on `reg_wr_en` that lasts exactly one cycle, and no two strobes fall on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `cclk` |
| rst | input | 1 | Synchronous active-high reset |
| ad0_cs | input | 1 | Shared pin: address strap in two-wire mode, active-low chip select in serial mode |
| cclk | input | 1 | Serial control clock |
| cdin | input | 1 | Serial control data in |
| spi_mode | output | 1 | 1 once serial mode has been selected |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | ADDR_W | Register address for the write |
| reg_wr_data | output | 8 | Register data for the write |

## Verification
The hardest situation to reach is the mode decision. A strap held low through reset must not count as an edge, and only a later true fall may select serial mode. The bench starts with the pin low and clocks identity-like patterns on the serial lines to show nothing is written. Only then does it raise the pin and open the first frame with the selecting fall. A second reset later in the run shows the choice is undone. Seeded random frames with bad identity bytes, truncated final bytes and pointer values near the top of the address space exercise the reject, discard and wrap paths. A bench model predicts the write list for each frame.

// File: rtl/spi_ctl_pkg.sv
`timescale 1ns/1ps
package spi_ctl_pkg;
  localparam int BYTE_W   = 8;
  localparam int STEP_BIT = 7;   // auto-advance flag position in the pointer byte

  typedef enum logic [1:0] {
    FR_IDENT = 2'd0,
    FR_PTR   = 2'd1,
    FR_DATA  = 2'd2,
    FR_DROP  = 2'd3
  } frame_state_e;
endpackage

// File: rtl/ctl_pin_sync.sv
`timescale 1ns/1ps
module ctl_pin_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_q,
  output logic [WIDTH-1:0] pin_prev,
  output logic             primed
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][WIDTH-1:0] pipe;
  logic [DEPTH-1:0]            fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {DEPTH{RST_VAL}};
      fill <= '0;
    end else begin
      pipe <= {pipe[DEPTH-2:0], pin_in};
      fill <= {fill[DEPTH-2:0], 1'b1};
    end
  end

  assign pin_q    = pipe[DEPTH-2];
  assign pin_prev = pipe[DEPTH-1];
  assign primed   = fill[DEPTH-1];
endmodule

// File: rtl/ctl_mode_latch.sv
`timescale 1ns/1ps
module ctl_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic primed,
  input  logic sel_q,
  input  logic sel_prev,
  output logic spi_mode
);
  logic fall_seen;

  assign fall_seen = primed & sel_prev & ~sel_q;

  always_ff @(posedge clk) begin
    if (rst) spi_mode <= 1'b0;
    else if (fall_seen) spi_mode <= 1'b1;
  end
endmodule

// File: rtl/ctl_byte_shift.sv
`timescale 1ns/1ps
module ctl_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sclk_rise,
  input  logic              sdata,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_ok
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shnext;

  assign shnext = {shreg[BYTE_W-2:0], sdata};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      bit_cnt <= '0;
      shreg   <= '0;
      byte_ok <= 1'b0;
    end else begin
      byte_ok <= 1'b0;
      if (sclk_rise) begin
        shreg <= shnext;
        if (bit_cnt == LAST) begin
          bit_cnt <= '0;
          byte_ok <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) byte_out <= '0;
    else if (enable && sclk_rise && bit_cnt == LAST) byte_out <= shnext;
  end
endmodule

// File: rtl/ctl_frame_ctrl.sv
`timescale 1ns/1ps
module ctl_frame_ctrl
  import spi_ctl_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter logic [7:0]  CHIP_ID = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_on,
  input  logic              byte_ok,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  frame_state_e      state;
  logic [ADDR_W-1:0] ptr;
  logic              step;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FR_IDENT;
      ptr     <= '0;
      step    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (!frame_on) begin
      state <= FR_IDENT;
      wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (byte_ok) begin
        unique case (state)
          FR_IDENT: state <= (byte_in == CHIP_ID) ? FR_PTR : FR_DROP;
          FR_PTR: begin
            ptr   <= byte_in[ADDR_W-1:0];
            step  <= byte_in[STEP_BIT];
            state <= FR_DATA;
          end
          FR_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= byte_in;
            if (step) ptr <= ptr + 1'b1;
          end
          FR_DROP: state <= FR_DROP;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ctl_port.sv
`timescale 1ns/1ps
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CHIP_ID     = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ad0_cs,
  input  logic              cclk,
  input  logic              cdin,
  output logic              spi_mode,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [7:0]        reg_wr_data
);
  localparam int PINS = 3;
  localparam int P_SEL = 2;
  localparam int P_CLK = 1;
  localparam int P_DAT = 0;

  logic [PINS-1:0]   pin_q;
  logic [PINS-1:0]   pin_prev;
  logic              primed;
  logic              frame_on;
  logic              sclk_rise;
  logic              byte_ok;
  logic [BYTE_W-1:0] byte_val;

  ctl_pin_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_in  ({ad0_cs, cclk, cdin}),
    .pin_q   (pin_q),
    .pin_prev(pin_prev),
    .primed  (primed)
  );

  ctl_mode_latch u_mode (
    .clk     (clk),
    .rst     (rst),
    .primed  (primed),
    .sel_q   (pin_q[P_SEL]),
    .sel_prev(pin_prev[P_SEL]),
    .spi_mode(spi_mode)
  );

  assign frame_on  = spi_mode & primed & ~pin_q[P_SEL];
  assign sclk_rise = pin_q[P_CLK] & ~pin_prev[P_CLK];

  ctl_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .enable   (frame_on),
    .sclk_rise(sclk_rise),
    .sdata    (pin_q[P_DAT]),
    .byte_out (byte_val),
    .byte_ok  (byte_ok)
  );

  ctl_frame_ctrl #(.ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .frame_on(frame_on),
    .byte_ok (byte_ok),
    .byte_in (byte_val),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data)
  );
endmodule

// File: rtl/spi_ctl_port_chk.sv
`timescale 1ns/1ps
module spi_ctl_port_chk (
  input logic clk,
  input logic rst,
  input logic spi_mode,
  input logic reg_wr_en,
  input logic byte_ok,
  input logic frame_on
);
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    spi_mode |=> spi_mode); // R1
  AST_NO_BYTE_BEFORE_MODE: assert property (@(posedge clk) disable iff (rst)
    !spi_mode |-> !byte_ok); // R3
  AST_WR_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(byte_ok)); // R4
  AST_WR_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(frame_on)); // R9
  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en); // R10
endmodule

bind spi_ctl_port spi_ctl_port_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .spi_mode (spi_mode),
  .reg_wr_en(reg_wr_en),
  .byte_ok  (byte_ok),
  .frame_on (frame_on)
);

// File: tb/spi_ctl_port_test.sv
`timescale 1ns/1ps
module spi_ctl_port_test;
  localparam int ADDR_W = 7;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ad0_cs = 1'b0;
  logic cclk = 1'b0;
  logic cdin = 1'b0;
  logic spi_mode;
  logic reg_wr_en;
  logic [ADDR_W-1:0] reg_wr_addr;
  logic [7:0] reg_wr_data;

  always #10 clk = ~clk;

  spi_ctl_port #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .ad0_cs(ad0_cs), .cclk(cclk), .cdin(cdin),
    .spi_mode(spi_mode), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int got_a[$], got_d[$], exp_a[$], exp_d[$];
  int pulse_err = 0;
  logic last_wr = 1'b0;
  logic [7:0] fb [16];

  always @(negedge clk) begin
    if (!rst && reg_wr_en) begin
      got_a.push_back(int'(reg_wr_addr));
      got_d.push_back(int'(reg_wr_data));
      if (last_wr) pulse_err++;
    end
    last_wr = rst ? 1'b0 : reg_wr_en;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    cdin = b;
    tick(HALF);
    cclk = 1'b1;
    tick(HALF);
    cclk = 1'b0;
  endtask

  task automatic frame(int nb, int extra);
    ad0_cs = 1'b0;
    tick(HALF);
    for (int i = 0; i < nb; i++)
      for (int j = 7; j >= 0; j--) send_bit(fb[i][j]);
    for (int j = 0; j < extra; j++) send_bit(fb[nb][7-j]);
    tick(HALF);
    ad0_cs = 1'b1;
    tick(4 * HALF);
  endtask

  function automatic void model(int nb);
    int ptr;
    bit inc;
    exp_a.delete();
    exp_d.delete();
    if (nb < 3 || fb[0] != 8'h30) return;
    ptr = int'(fb[1][ADDR_W-1:0]);
    inc = fb[1][7];
    for (int i = 2; i < nb; i++) begin
      exp_a.push_back(ptr);
      exp_d.push_back(int'(fb[i]));
      if (inc) ptr = (ptr + 1) % (1 << ADDR_W);
    end
  endfunction

  task automatic run_frame(string req, int nb, int extra);
    int n;
    got_a.delete();
    got_d.delete();
    model(nb);
    frame(nb, extra);
    tick(10);
    chk(req, "write count", got_a.size(), exp_a.size());
    n = (got_a.size() < exp_a.size()) ? got_a.size() : exp_a.size();
    for (int i = 0; i < n; i++) begin
      chk(req, "write addr", got_a[i], exp_a[i]);
      chk(req, "write data", got_d[i], exp_d[i]);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    int nb, extra;
    seed = $urandom(32'd4711);
    // reset with the strap pin held low
    tick(3);
    rst = 1'b0;
    tick(2);
    chk("R1", "spi_mode after reset", int'(spi_mode), 0);
    // two-wire style traffic with strap low: no mode change, no writes (R2, R3)
    got_a.delete();
    for (int k = 0; k < 4; k++)
      for (int j = 7; j >= 0; j--) send_bit(((k == 0 ? 8'h30 : 8'h81) >> j) & 1);
    tick(10);
    chk("R2", "spi_mode with strap low", int'(spi_mode), 0);
    chk("R3", "writes before serial mode", got_a.size(), 0);
    // strap high and more clocking: still nothing
    ad0_cs = 1'b1;
    tick(10);
    for (int j = 7; j >= 0; j--) send_bit((8'h30 >> j) & 1);
    tick(10);
    chk("R3", "spi_mode with strap high", int'(spi_mode), 0);
    chk("R3", "writes with strap high", got_a.size(), 0);

    // first fall selects serial mode and the frame is accepted (R1, R4, R6)
    fb[0] = 8'h30; fb[1] = 8'h05; fb[2] = 8'hA5;
    run_frame("R6", 3, 0);
    chk("R1", "spi_mode after first fall", int'(spi_mode), 1);

    // auto-advance across the top address (R7)
    fb[0] = 8'h30; fb[1] = 8'hFE; fb[2] = 8'h11; fb[3] = 8'h22; fb[4] = 8'h33; fb[5] = 8'h44;
    run_frame("R7", 6, 0);

    // flag clear: same register every time (R8)
    fb[0] = 8'h30; fb[1] = 8'h12; fb[2] = 8'h01; fb[3] = 8'h80; fb[4] = 8'hC3;
    run_frame("R8", 5, 0);

    // bad identity byte, then a good frame (R5)
    fb[0] = 8'h31; fb[1] = 8'h30; fb[2] = 8'h02; fb[3] = 8'h55;
    run_frame("R5", 4, 0);
    fb[0] = 8'h30; fb[1] = 8'h03; fb[2] = 8'h5A;
    run_frame("R5", 3, 0);

    // partial byte dropped (R9)
    fb[0] = 8'h30; fb[1] = 8'h09; fb[2] = 8'hF0;
    run_frame("R9", 2, 4);
    fb[0] = 8'h30; fb[1] = 8'h0A;
    run_frame("R9", 2, 0);
    fb[0] = 8'h30; fb[1] = 8'h0B; fb[2] = 8'h3C; fb[3] = 8'hFF;
    run_frame("R9", 3, 5);

    // seeded random frames
    for (int f = 0; f < 40; f++) begin
      nb = 1 + $urandom_range(0, 5);
      for (int i = 0; i < 16; i++) fb[i] = 8'($urandom());
      if ($urandom_range(0, 3) != 0) fb[0] = 8'h30;
      if ($urandom_range(0, 2) == 0) fb[1][6:0] = 7'h7E;
      extra = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      run_frame("R4", nb, extra);
    end

    chk("R1", "spi_mode held", int'(spi_mode), 1);
    chk("R10", "back-to-back strobes", pulse_err, 0);

    // reset clears mode, then a fresh fall selects it again (R1)
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(6);
    chk("R1", "spi_mode after second reset", int'(spi_mode), 0);
    fb[0] = 8'h30; fb[1] = 8'h81; fb[2] = 8'h77; fb[3] = 8'h66;
    run_frame("R7", 4, 0);
    chk("R1", "spi_mode reselected", int'(spi_mode), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule